// File: doc/BRIEF.md
# Pulse-Width Coded Motor Command Transmitter

This block turns one motor command into a serial pulse train on a single pin. Each command word has 16 bits: an 11-bit throttle value, a telemetry-request flag and a 4-bit checksum folded from the first twelve bits. The word goes out most significant bit first. Every bit occupies a slot of fixed length, and the length of the active phase at the start of the slot encodes the value. A seventeenth slot with no active phase closes the frame, so the line is back at rest before the next command can start.

A prescaler built into the block divides the system clock by a run-time value, and the slot timing counts the prescaled ticks. The same logic therefore serves several line rates. A mode input selects the bidirectional variant. In that mode the line polarity is inverted and the checksum is complemented. A new command is taken only while the block is idle. It reports activity with a busy level and signals the end of each frame with a one-clock done pulse.

Top module: `motor_frame_tx`

## Requirements
- R1: The frame word puts throttle in bits 15:5, the telemetry flag in bit 4 and the checksum in bits 3:0, and the line sends it bit 15 first.
- R2: In normal mode the checksum is v[3:0] ^ v[7:4] ^ v[11:8], where v is the 12-bit field formed by the throttle and the telemetry flag (frame bits 15:4).
- R3: In bidirectional mode the checksum is the bitwise complement of the R2 value.
- R4: Each bit slot lasts 20 ticks. The line is active for the first 14 ticks of a one and for the first 7 ticks of a zero, and idle for the rest of the slot.
- R5: A 17th slot of 20 ticks with no active time follows the 16 data slots, and busy stays high for exactly 17 slots.
- R6: In normal mode the line idles low and pulses high. In bidirectional mode it idles high and pulses low. While idle, the line follows the mode input.
- R7: One tick lasts rate_div+1 clocks, so a frame keeps busy high for 340*(rate_div+1) clocks.
- R8: A start strobe seen at a clock edge while idle latches the inputs, and busy is high from the next cycle.
- R9: A start strobe while busy is ignored: the frame in flight is unchanged and no further frame follows it.
- R10: done is high for exactly one clock, in the first cycle in which busy is low after a frame.
- R11: After reset, busy and done are low and the line is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_div | input | 8 | Tick divisor minus one |
| throttle | input | 11 | Throttle value for the next frame |
| telem_req | input | 1 | Telemetry-request flag for the next frame |
| bidir_mode | input | 1 | Selects inverted polarity and complemented checksum |
| start | input | 1 | Requests a frame when idle |
| line_out | output | 1 | Serial output pin |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-clock pulse at the end of a frame |

## Verification
The hardest case to reach is a start strobe that arrives in the middle of a frame and carries different command data. Only the end of that frame shows whether the strobe was dropped, so the bench raises start with new data partway through a frame. It then decodes the whole frame, expecting the original data, and watches busy for several cycles afterwards to confirm that no second frame begins. A second difficult case is a start placed in the very cycle where done is high. The bench issues one there to show that a frame can follow another with no gap.

// File: rtl/mtx_pkg.sv
// Shared constants and the checksum fold for the motor frame transmitter.
// Assumes a 12-bit checksum field split into three 4-bit nibbles.
package mtx_pkg;
    parameter int THR_W      = 11;
    parameter int DATA_BITS  = 16;
    parameter int CRC_W      = 4;
    parameter int SLOT_TICKS = 20;
    parameter int ONE_TICKS  = 14;
    parameter int ZERO_TICKS = 7;
    parameter int FIELD_W    = THR_W + 1;

    // Fold the 12-bit field into a 4-bit checksum
    function automatic logic [CRC_W-1:0] fold_crc(input logic [FIELD_W-1:0] v);
        return v[3:0] ^ v[7:4] ^ v[11:8];
    endfunction
endpackage

// File: rtl/mtx_frame_pack.sv
// Builds the 16-bit command word from throttle, telemetry flag and mode.
// Purely combinational; the caller latches the result at frame start.
module mtx_frame_pack
    import mtx_pkg::*;
(
    input  logic [THR_W-1:0]     throttle,
    input  logic                 telem_req,
    input  logic                 invert,
    output logic [DATA_BITS-1:0] word
);
    logic [FIELD_W-1:0] field;
    logic [CRC_W-1:0]   crc;

    // Form field and checksum, complemented in inverted mode
    always_comb begin
        field = {throttle, telem_req};
        crc   = fold_crc(field);
        if (invert)
            crc = ~crc;
        word  = {field, crc};
    end
endmodule

// File: rtl/mtx_tick_gen.sv
// Programmable prescaler: one tick every DIV+1 clocks while running.
// Assumes clear is asserted when a frame is loaded, to phase-align ticks.
module mtx_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    // Tick fires when the counter reaches the divisor
    always_comb tick = run && (cnt_q == div);

    // Count clocks between ticks, restart on clear or when idle
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || !run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mtx_slot_engine.sv
// Walks 16 data slots plus one blank slot, each SLOT_TICKS ticks long,
// and drives the line with a width-coded active phase at the slot start.
// Assumes load is only asserted while busy is low.
module mtx_slot_engine
    import mtx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] word_in,
    input  logic                 inv_in,
    input  logic                 idle_level,
    output logic                 busy,
    output logic                 done,
    output logic                 line
);
    localparam int NSLOTS = DATA_BITS + 1;
    localparam int SLOT_W = $clog2(NSLOTS);
    localparam int TCK_W  = $clog2(SLOT_TICKS);
    localparam int IDX_W  = $clog2(DATA_BITS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NSLOTS - 1);
    localparam logic [SLOT_W-1:0] BLANK     = SLOT_W'(DATA_BITS);
    localparam logic [TCK_W-1:0]  LAST_TICK = TCK_W'(SLOT_TICKS - 1);
    localparam logic [TCK_W-1:0]  W_ONE     = TCK_W'(ONE_TICKS);
    localparam logic [TCK_W-1:0]  W_ZERO    = TCK_W'(ZERO_TICKS);
    localparam logic [IDX_W-1:0]  TOP_IDX   = IDX_W'(DATA_BITS - 1);

    logic [SLOT_W-1:0]    slot_q;
    logic [TCK_W-1:0]     tcnt_q;
    logic [DATA_BITS-1:0] word_q;
    logic                 inv_q;
    logic                 busy_q;
    logic                 done_q;
    logic                 cur_bit;
    logic                 active;

    // Slot and tick sequencing, frame start and end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            slot_q <= '0;
            tcnt_q <= '0;
            word_q <= '0;
            inv_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                busy_q <= 1'b1;
                slot_q <= '0;
                tcnt_q <= '0;
                word_q <= word_in;
                inv_q  <= inv_in;
            end else if (busy_q && tick) begin
                if (tcnt_q == LAST_TICK) begin
                    tcnt_q <= '0;
                    if (slot_q == LAST_SLOT) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end
    end

    // Active phase: leading part of a data slot, none in the blank slot
    always_comb begin
        cur_bit = word_q[TOP_IDX - slot_q[IDX_W-1:0]];
        active  = (slot_q < BLANK) && (tcnt_q < (cur_bit ? W_ONE : W_ZERO));
    end

    // Line level with frame polarity, or idle level between frames
    always_comb line = busy_q ? (active ^ inv_q) : idle_level;

    assign busy = busy_q;
    assign done = done_q;
endmodule

// File: rtl/motor_frame_tx.sv
// Top of the motor command transmitter: packs the word, runs the
// prescaler and slot engine. Accepts start only while idle.
module motor_frame_tx
    import mtx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] rate_div,
    input  logic [10:0]      throttle,
    input  logic             telem_req,
    input  logic             bidir_mode,
    input  logic             start,
    output logic             line_out,
    output logic             busy,
    output logic             done
);
    logic [DATA_BITS-1:0] packed_word;
    logic                 accept;
    logic                 tick;

    // Accept a request only between frames
    always_comb accept = start && !busy;

    mtx_frame_pack u_pack (
        .throttle  (throttle),
        .telem_req (telem_req),
        .invert    (bidir_mode),
        .word      (packed_word)
    );

    mtx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .clear (accept),
        .div   (rate_div),
        .tick  (tick)
    );

    mtx_slot_engine u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .load       (accept),
        .word_in    (packed_word),
        .inv_in     (bidir_mode),
        .idle_level (bidir_mode),
        .busy       (busy),
        .done       (done),
        .line       (line_out)
    );
endmodule

// File: rtl/motor_frame_tx_chk.sv
// Protocol checker for motor_frame_tx, bound to every instance.
module motor_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic tick
);
    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_tick_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tick);
endmodule

bind motor_frame_tx motor_frame_tx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .tick  (tick)
);

// File: tb/motor_frame_tx_tb.sv
module motor_frame_tx_tb;
    typedef struct packed {
        logic [15:0] word;
        logic        inv;
        logic [7:0]  div;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rate_div = '0;
    logic [10:0] throttle = '0;
    logic       telem_req = 1'b0;
    logic       bidir_mode = 1'b0;
    logic       start = 1'b0;
    logic       line_out, busy, done;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    exp_t expq[$];

    always #10 clk = ~clk;

    motor_frame_tx u_dut (
        .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .throttle(throttle),
        .telem_req(telem_req), .bidir_mode(bidir_mode), .start(start),
        .line_out(line_out), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word from R1/R2/R3
    function automatic logic [15:0] model_word(input logic [10:0] t, input logic tel, input logic inv);
        logic [11:0] v;
        logic [3:0]  c;
        v = {t, tel};
        c = v[3:0] ^ v[7:4] ^ v[11:8];
        if (inv) c = ~c;
        return {v, c};
    endfunction

    // Driver: wait for idle, strobe start, push expectation
    task automatic send(input logic [10:0] t, input logic tel, input logic inv, input logic [7:0] dv);
        exp_t e;
        while (busy) @(negedge clk);
        throttle = t; telem_req = tel; bidir_mode = inv; rate_div = dv;
        start = 1'b1;
        e.word = model_word(t, tel, inv); e.inv = inv; e.div = dv;
        expq.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
    endtask

    // Monitor state
    bit   in_frame = 0;
    exp_t cur;
    int   n = 0;
    int   acnt [17];
    bit   contig = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                int slen, s, p;
                if (!in_frame) begin
                    in_frame = 1; n = 0; contig = 1;
                    foreach (acnt[i]) acnt[i] = 0;
                    if (expq.size() == 0) begin
                        check(0, "R9 unexpected frame", 1, 0);
                        cur = '0;
                    end else cur = expq.pop_front();
                end
                slen = 20 * (cur.div + 1);
                s = n / slen; p = n % slen;
                if (s < 17 && (line_out != cur.inv)) begin
                    if (p != acnt[s]) contig = 0;
                    acnt[s]++;
                end
                n++;
            end else if (in_frame) begin
                int u;
                logic [15:0] got;
                bit widths_ok;
                in_frame = 0;
                frames_seen++;
                u = cur.div + 1;
                got = '0; widths_ok = 1;
                for (int s2 = 0; s2 < 16; s2++) begin
                    if (acnt[s2] == 14 * u) got[15 - s2] = 1'b1;
                    else if (acnt[s2] != 7 * u) widths_ok = 0;
                end
                check(got == cur.word, "R1 R2 R3 decoded word", got, cur.word);
                check(widths_ok && contig, "R4 active widths", widths_ok, 1);
                check(acnt[16] == 0, "R5 blank slot", acnt[16], 0);
                check(n == 340 * u, "R5 R7 frame length", n, 340 * u);
                check(done == 1'b1, "R10 done at end", done, 1);
            end else begin
                if (done) check(0, "R10 stray done", 1, 0);
            end
        end
    end

    bit finished = 0;
    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0, "R11 reset flags", {busy, done}, 0);
        check(line_out == 1'b0, "R11 R6 idle low normal", line_out, 0);
        bidir_mode = 1'b1; #1;
        check(line_out == 1'b1, "R11 R6 idle high bidir", line_out, 1);
        bidir_mode = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        send(11'd0, 1'b0, 1'b0, 8'd0);
        send(11'h7FF, 1'b1, 1'b0, 8'd0);
        send(11'h2AA, 1'b0, 1'b1, 8'd0);
        send(11'd48, 1'b1, 1'b1, 8'd2);
        while (busy) @(negedge clk);
        @(negedge clk); #1;
        check(line_out == 1'b1, "R6 idle high after bidir frame", line_out, 1);

        // R9: mid-frame start with other data must be dropped
        send(11'd1000, 1'b0, 1'b0, 8'd1);
        repeat (300) @(negedge clk);
        throttle = 11'h155; telem_req = 1'b1; bidir_mode = 1'b1;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        bidir_mode = 1'b0;
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R9 no frame after ignored start", busy, 0);
        check(frames_seen == 5, "R9 frame count", frames_seen, 5);

        // R8/R10: start in the done cycle, back to back
        send(11'h123, 1'b1, 1'b0, 8'd0);
        while (!done) @(negedge clk);
        send(11'h456, 1'b0, 1'b0, 8'd0);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(frames_seen == 7, "R8 back-to-back frames", frames_seen, 7);
        check(expq.size() == 0, "R9 queue drained", expq.size(), 0);
        finish_run();
    end
endmodule